// File: doc/BRIEF.md
# Byte/Word Switchable ROM Read Port

This block is the read front end of a read-only memory that can be viewed either as 16-bit words or as 8-bit bytes. A mode input picks the view. In word mode, one shared pin carries data bit 15 and every data lane is driven. In byte mode, the same pin becomes an extra address bit that sits below the word address and chooses which half of the addressed word appears on the low lane. The byte view therefore has exactly twice as many locations as the word view.

An active-low chip enable and an active-low output enable gate the outputs. The top quarter of the word address space holds no data, and a read there leaves every lane undriven. Tri-state pins are modelled as data buses plus separate drive enables for each lane. The low lane is bits 0 to 7, the high lane is bits 8 to 14, and the shared pin has its own data bit and enable. The contents come from an internal array that is computed when the block is elaborated. Every output is registered, and a request taken at one clock edge is visible a fixed, parameterised number of edges later.

Top module: `bw_rom_port`

## Requirements
- R1: A synchronous reset clears every lane enable and every data bit, and sets `standby`. These idle values stay at the outputs until requests taken after reset reach the outputs.
- R2: The inputs captured at one rising edge appear on the outputs after LATENCY rising edges (LATENCY >= 2, default 3).
- R3: In word mode (`wide`=1, `cs_n`=0, `oe_n`=0, no hole), `lo_en`, `hi_en` and `msb_en` are all 1. `data_o` carries word bits 14..0 and `msb_o` carries word bit 15.
- R4: In byte mode (`wide`=0) with `shr_in`=0, only `lo_en` is 1. `data_o[7:0]` carries word bits 7..0, and `hi_en` and `msb_en` are 0.
- R5: In byte mode with `shr_in`=1, only `lo_en` is 1 and `data_o[7:0]` carries word bits 15..8.
- R6: With `cs_n`=1, all enables are 0 and `standby` is 1, whatever the other inputs are.
- R7: With `cs_n`=0 and `oe_n`=1, all enables are 0 and `standby` is 0.
- R8: With `cs_n`=0 and `oe_n`=0, a word address whose two most significant bits are both 1 leaves all enables at 0 in either mode.
- R9: Any output bit whose lane enable is 0 reads 0.
- R10: The word stored at index i has high byte (7*i+3) mod 256 and low byte (i mod 256) XOR 0x5C.
- R11: For every word address outside the hole, the upper byte read followed by the lower byte read equals the 16-bit word read.
- R12: In word mode the value on `shr_in` has no effect on the word that is returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| wide | input | 1 | 1 = word mode, 0 = byte mode |
| addr | input | WORD_AW | Word address |
| shr_in | input | 1 | Shared pin as input: byte-select address bit in byte mode |
| data_o | output | 15 | Data bits 14..0 |
| lo_en | output | 1 | Drive enable for bits 7..0 |
| hi_en | output | 1 | Drive enable for bits 14..8 |
| msb_o | output | 1 | Shared pin as output: data bit 15 |
| msb_en | output | 1 | Drive enable for the shared pin |
| standby | output | 1 | Chip enable is inactive |

## Verification
The bench aims at the shared pin. A design that took the byte select from the wrong source, or swapped the halves, would fail the byte-versus-word concatenation over the whole populated space. A design that drove the shared pin in byte mode would contend with the address driver and shows up as `msb_en` set. Random traffic hits the empty quarter in both modes, where a design that forgot the hole would drive stale or out-of-range data. It also toggles the output enable separately from the chip enable, which separates the standby case from the operating case with outputs off. A reset in the middle of traffic checks that requests still in flight are dropped rather than presented.

// File: rtl/bw_rom_pkg.sv
package bw_rom_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int DQ_W   = WORD_W - 1;

  typedef struct packed {
    logic drive;
    logic wide;
    logic upper;
    logic standby;
  } rd_ctrl_t;

  localparam rd_ctrl_t CTRL_IDLE = '{drive: 1'b0, wide: 1'b0, upper: 1'b0, standby: 1'b1};

  function automatic logic [WORD_W-1:0] rom_word(input int unsigned idx);
    logic [BYTE_W-1:0] hb;
    logic [BYTE_W-1:0] lb;
    hb = BYTE_W'((idx * 7 + 3) & 255);
    lb = BYTE_W'(idx & 255) ^ 8'h5C;
    return {hb, lb};
  endfunction
endpackage

// File: rtl/bw_rom_decode.sv
module bw_rom_decode
  import bw_rom_pkg::*;
(
  input  logic       cs_n,
  input  logic       oe_n,
  input  logic       wide,
  input  logic [1:0] top_bits,
  input  logic       shr_in,
  output rd_ctrl_t   ctrl,
  output logic       rd_en
);
  logic hole;

  always_comb begin
    hole         = &top_bits;
    ctrl.standby = cs_n;
    ctrl.drive   = !cs_n && !oe_n && !hole;
    ctrl.wide    = wide;
    ctrl.upper   = !wide && shr_in;
    rd_en        = ctrl.drive;
  end
endmodule

// File: rtl/bw_rom_array.sv
module bw_rom_array
  import bw_rom_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DEPTH = 3 << (AW - 2)
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  output logic [WORD_W-1:0] q
);
  logic [WORD_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = rom_word(i);
  end

  always_ff @(posedge clk) begin
    if (rd_en) q <= mem[addr];
  end
endmodule

// File: rtl/bw_rom_delay.sv
module bw_rom_delay #(
  parameter int           W       = 1,
  parameter int           STAGES  = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_pipe
      logic [W-1:0] sr [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) sr[i] <= RST_VAL;
        end else begin
          sr[0] <= d;
          for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
        end
      end
      assign q = sr[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/bw_rom_port.sv
module bw_rom_port
  import bw_rom_pkg::*;
#(
  parameter int WORD_AW = 8,
  parameter int LATENCY = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_n,
  input  logic               oe_n,
  input  logic               wide,
  input  logic [WORD_AW-1:0] addr,
  input  logic               shr_in,
  output logic [DQ_W-1:0]    data_o,
  output logic               lo_en,
  output logic               hi_en,
  output logic               msb_o,
  output logic               msb_en,
  output logic               standby
);
  localparam int WORDS   = 3 << (WORD_AW - 2);
  localparam int MID_STG = LATENCY - 2;
  localparam int CTRL_W  = $bits(rd_ctrl_t);

  rd_ctrl_t          ctrl_d;
  rd_ctrl_t          ctrl_s1;
  rd_ctrl_t          ctrl_s2;
  logic              rd_en;
  logic [WORD_W-1:0] word_s1;
  logic [WORD_W-1:0] word_s2;
  logic [CTRL_W-1:0] ctrl_s2_bits;

  bw_rom_decode u_dec (
    .cs_n    (cs_n),
    .oe_n    (oe_n),
    .wide    (wide),
    .top_bits(addr[WORD_AW-1 -: 2]),
    .shr_in  (shr_in),
    .ctrl    (ctrl_d),
    .rd_en   (rd_en)
  );

  bw_rom_array #(.AW(WORD_AW), .DEPTH(WORDS)) u_arr (
    .clk  (clk),
    .rd_en(rd_en),
    .addr (addr),
    .q    (word_s1)
  );

  always_ff @(posedge clk) begin
    if (rst) ctrl_s1 <= CTRL_IDLE;
    else     ctrl_s1 <= ctrl_d;
  end

  bw_rom_delay #(.W(CTRL_W), .STAGES(MID_STG), .RST_VAL(CTRL_IDLE)) u_dly_ctrl (
    .clk(clk),
    .rst(rst),
    .d  (ctrl_s1),
    .q  (ctrl_s2_bits)
  );
  assign ctrl_s2 = rd_ctrl_t'(ctrl_s2_bits);

  bw_rom_delay #(.W(WORD_W), .STAGES(MID_STG), .RST_VAL('0)) u_dly_word (
    .clk(clk),
    .rst(rst),
    .d  (word_s1),
    .q  (word_s2)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o  <= '0;
      lo_en   <= 1'b0;
      hi_en   <= 1'b0;
      msb_o   <= 1'b0;
      msb_en  <= 1'b0;
      standby <= 1'b1;
    end else begin
      standby <= ctrl_s2.standby;
      data_o  <= '0;
      lo_en   <= 1'b0;
      hi_en   <= 1'b0;
      msb_o   <= 1'b0;
      msb_en  <= 1'b0;
      if (ctrl_s2.drive) begin
        lo_en <= 1'b1;
        if (ctrl_s2.wide) begin
          data_o <= word_s2[DQ_W-1:0];
          msb_o  <= word_s2[WORD_W-1];
          hi_en  <= 1'b1;
          msb_en <= 1'b1;
        end else if (ctrl_s2.upper) begin
          data_o[BYTE_W-1:0] <= word_s2[WORD_W-1:BYTE_W];
        end else begin
          data_o[BYTE_W-1:0] <= word_s2[BYTE_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/bw_rom_port_chk.sv
module bw_rom_port_chk (
  input logic        clk,
  input logic        rst,
  input logic [14:0] data_o,
  input logic        lo_en,
  input logic        hi_en,
  input logic        msb_o,
  input logic        msb_en,
  input logic        standby
);
  p_word_all_lanes_r3: assert property (@(posedge clk) disable iff (rst)
    hi_en |-> (lo_en && msb_en));

  p_byte_pin_free_r4: assert property (@(posedge clk) disable iff (rst)
    msb_en |-> hi_en);

  p_standby_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    standby |-> (!lo_en && !hi_en && !msb_en));

  p_low_lane_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !lo_en |-> (data_o[7:0] == 8'h00));

  p_high_lane_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !hi_en |-> (data_o[14:8] == 7'h00));

  p_pin_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !msb_en |-> !msb_o);
endmodule

bind bw_rom_port bw_rom_port_chk u_chk (.*);

// File: tb/bw_rom_port_bench.sv
`timescale 1ns/1ps
module bw_rom_port_bench;
  localparam int AW  = 8;
  localparam int LAT = 3;
  localparam int POP = 3 << (AW - 2);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1;
  logic          oe_n = 1'b1;
  logic          wide = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          shr_in = 1'b0;
  logic [14:0]   data_o;
  logic          lo_en, hi_en, msb_o, msb_en, standby;

  always #2 clk = ~clk;

  bw_rom_port #(.WORD_AW(AW), .LATENCY(LAT)) u_bw_rom_port (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .wide(wide),
    .addr(addr), .shr_in(shr_in), .data_o(data_o), .lo_en(lo_en),
    .hi_en(hi_en), .msb_o(msb_o), .msb_en(msb_en), .standby(standby)
  );

  typedef struct {
    logic [14:0] d;
    logic        msb;
    logic        lo;
    logic        hi;
    logic        men;
    logic        sb;
    string       tag;
  } exp_t;

  exp_t        expq[$];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 0;
  logic [14:0] got_d;
  logic        got_msb;

  // R10: stored word contents
  function automatic logic [15:0] ref_word(input int i);
    int h, l;
    h = (i * 7 + 3) % 256;
    l = (i % 256) ^ 'h5C;
    return {h[7:0], l[7:0]};
  endfunction

  function automatic exp_t model(input logic c, input logic o, input logic w,
                                 input logic [AW-1:0] a, input logic s);
    exp_t e;
    logic [15:0] v;
    e = '{d: '0, msb: 1'b0, lo: 1'b0, hi: 1'b0, men: 1'b0, sb: c, tag: ""};
    if (c)                     e.tag = "R6";
    else if (o)                e.tag = "R7";
    else if (a[AW-1] && a[AW-2]) e.tag = "R8";
    else begin
      v = ref_word(int'(a));
      e.lo = 1'b1;
      if (w) begin
        e.d = v[14:0]; e.msb = v[15]; e.hi = 1'b1; e.men = 1'b1;
        e.tag = s ? "R12" : "R3";
      end else if (s) begin
        e.d[7:0] = v[15:8]; e.tag = "R5";
      end else begin
        e.d[7:0] = v[7:0]; e.tag = "R4";
      end
    end
    return e;
  endfunction

  // one cycle: compare outputs to the request LAT cycles back (R2, R9), then drive
  task automatic step(input logic r, input logic c, input logic o, input logic w,
                      input logic [AW-1:0] a, input logic s);
    exp_t e;
    @(negedge clk);
    got_d   = data_o;
    got_msb = msb_o;
    if (expq.size() == LAT) begin
      e = expq.pop_front();
      n_chk++;
      if (data_o !== e.d || msb_o !== e.msb || lo_en !== e.lo || hi_en !== e.hi ||
          msb_en !== e.men || standby !== e.sb) begin
        n_bad++;
        $display("FAIL %s/R2/R9: got d=%h msb=%b en=%b%b%b sb=%b exp d=%h msb=%b en=%b%b%b sb=%b",
                 e.tag, data_o, msb_o, lo_en, hi_en, msb_en, standby,
                 e.d, e.msb, e.lo, e.hi, e.men, e.sb);
      end
    end
    if (r) begin
      expq.delete();
      repeat (LAT) expq.push_back('{d: '0, msb: 1'b0, lo: 1'b0, hi: 1'b0, men: 1'b0, sb: 1'b1, tag: "R1"});
    end else begin
      expq.push_back(model(c, o, w, a, s));
    end
    rst = r; cs_n = c; oe_n = o; wide = w; addr = a; shr_in = s;
  endtask

  task automatic read(input logic w, input int a, input logic s,
                      output logic [15:0] res);
    step(1'b0, 1'b0, 1'b0, w, AW'(a), s);
    repeat (LAT) step(1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b0);
    res = {got_msb, got_d};
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] wv, wv1, lb, ub;
    repeat (4) step(1'b1, 1'b1, 1'b1, 1'b0, '0, 1'b0);
    // R1: idle outputs drain after release, then directed cases R3..R8
    step(1'b0, 1'b0, 1'b0, 1'b1, AW'(5), 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, AW'(5), 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, AW'(5), 1'b1);
    step(1'b0, 1'b1, 1'b0, 1'b1, AW'(9), 1'b0);
    step(1'b0, 1'b0, 1'b1, 1'b1, AW'(9), 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1, AW'(POP), 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, AW'(POP + 7), 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b1, AW'(POP - 1), 1'b1);

    // R11 / R12: byte-versus-word equivalence over every populated word
    for (int i = 0; i < POP; i++) begin
      read(1'b1, i, 1'b0, wv);
      read(1'b1, i, 1'b1, wv1);
      read(1'b0, i, 1'b0, lb);
      read(1'b0, i, 1'b1, ub);
      n_chk++;
      if ({ub[7:0], lb[7:0]} !== wv) begin
        n_bad++;
        $display("FAIL R11 addr %0d: got %h expected %h", i, {ub[7:0], lb[7:0]}, wv);
      end
      n_chk++;
      if (wv1 !== wv) begin
        n_bad++;
        $display("FAIL R12 addr %0d: got %h expected %h", i, wv1, wv);
      end
    end

    // random traffic with a reset in the middle (R1, R2, R6, R7, R8)
    for (int k = 0; k < 3000; k++) begin
      logic r;
      r = (k >= 1500 && k < 1502);
      step(r, ($urandom % 8) == 0, ($urandom % 8) == 0, 1'($urandom),
           AW'($urandom), 1'($urandom));
    end
    repeat (LAT) step(1'b0, 1'b1, 1'b1, 1'b0, '0, 1'b0);
    finish_run();
  end
endmodule